// File: doc/BRIEF.md
# Multi-mode serial bit-clock timer

This block is a down-counting timer that paces a serial shifter. It produces a timer output level and a shift clock for neighbouring transmit and receive shift registers. It also raises a sticky compare flag and one-cycle strobes that tell a transmit shifter to load and a receive shifter to store. The counter is split into two equal halves. These halves run as one wide counter, as a cascaded bit-timing/bit-count pair, or as a two-phase PWM whose halves set the high and low widths.

A start pulse loads the counter from the compare value and drives the output to its configured starting level. The counter then steps on every clock, or on both edges of a synchronised external pin, as the step-source select chooses. A restart pulse reloads the counter while it runs. An optional start-bit phase makes the first rising shift-clock edge reload the counter instead of stepping it. Dropping the arm input freezes the count, shows the starting level on the output and holds the shift clock low.

Top module: `bitclk_timer`

## Requirements
- R1: After reset, `flag_o`, `tx_load_o`, `rx_store_o` and `shift_clk_o` are low, and `tmr_out_o` shows the starting level that `out_init_i` selects.
- R2: A clock edge with `arm_i` and `start_i` both high loads the counter from `cmp_i` and sets the output to its starting level. Stepping begins on the following edge.
- R3: `dec_sel_i` selects the step source and the shift clock. 00 steps on every clock, with the shift clock equal to the timer output. 01 steps on pin edges, with the shift clock equal to the timer output. 10 steps on pin edges, with the shift clock equal to the synchronised pin. 11 steps on pin edges, with the shift clock equal to the inverted synchronised pin.
- R4: In the pin-driven settings, both the rising and the falling edge of `pin_i` each produce one step.
- R5: A `rst_cond_i` edge while running reloads the counter from `cmp_i`. With `out_init_i[1]`=1 the output also returns to its starting level. With `out_init_i[1]`=0 it is left as it was.
- R6: With `start_bit_i` set at start, the first rising edge of the shift clock reloads the counter in place of a step. A compare event therefore needs one extra step.
- R7: Mode 00, the cascaded mode, works as follows. When the low half is zero on a step, the output toggles, the low half reloads from `cmp_i[7:0]` and the high half counts down. With low value L and high value H, the output toggles every L+1 steps and a compare event falls on step (H+1)(L+1).
- R8: Mode 01 is PWM. The low half counts only while the output is high, and the high half only while it is low. The output toggles when the active half is zero on a step. From a high start, the high phase lasts L+1 steps, the low phase lasts H+1 steps, and the compare event ends the low phase.
- R9: In modes 10 and 11, the wide modes, a compare event occurs on the step taken while the whole counter is zero. That is step N+1 after a load of N.
- R10: A compare event reloads the counter, toggles the output and sets `flag_o`. It also raises `tx_load_o` and `rx_store_o` for the one cycle after that edge.
- R11: `flag_o` stays set until `flag_clr_i` is high on an edge. When a clear and a compare event fall on the same edge, the flag stays set.
- R12: While `arm_i` is low, the counter holds its value, `tmr_out_o` shows the starting level and `shift_clk_o` is low. On re-arming, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Timer allowed to run; low freezes it |
| start_i | input | 1 | Enable condition: load and start |
| rst_cond_i | input | 1 | Restart condition: reload while running |
| mode_i | input | 2 | 00 cascaded, 01 PWM, 10/11 wide |
| dec_sel_i | input | 2 | Step source and shift-clock select |
| out_init_i | input | 2 | Bit 0: starting level low; bit 1: restart re-initialises output |
| start_bit_i | input | 1 | Enable the start-bit reload |
| pin_i | input | 1 | External pin or trigger |
| cmp_i | input | CNT_W | Compare / reload value |
| flag_clr_i | input | 1 | Clear the compare flag |
| tmr_out_o | output | 1 | Timer output |
| shift_clk_o | output | 1 | Shift clock for the shifters |
| flag_o | output | 1 | Sticky compare flag |
| tx_load_o | output | 1 | Transmit shifter load strobe |
| rx_store_o | output | 1 | Receive shifter store strobe |

## Verification
The start edge is step zero. A clock-stepped compare then shows on the flag, the strobes and the output one cycle after step N+1, and the bench counts falling edges after the start edge to find that cycle. A pin edge crosses two synchroniser stages and then the counter register, so it lands on the third clock edge. The bench holds each pin level for five cycles before judging the flag or the shift clock. Restart, disarm and flag clear all act on the next edge, and the bench samples one falling edge after each of them.

// File: rtl/bct_pkg.sv
package bct_pkg;
   typedef enum logic [1:0] {
      MODE_CASCADE = 2'b00,
      MODE_PWM     = 2'b01,
      MODE_WIDE    = 2'b10,
      MODE_WIDE_B  = 2'b11
   } tmr_mode_e;

   // starting level: bit 0 low selects a high start
   function automatic logic start_level(input logic [1:0] sel);
      return ~sel[0];
   endfunction
endpackage

// File: rtl/bct_pin_sync.sv
module bct_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic level_o,
   output logic edge_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("bct_pin_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= pin_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign edge_o  = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/bct_count_core.sv
module bct_count_core
   import bct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,
   input  logic             start_i,
   input  logic             rst_cond_i,
   input  logic             tick_i,
   input  logic             sclk_rise_i,
   input  logic             start_bit_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       out_init_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             out_o,
   output logic             run_o,
   output logic             evt_o,
   output logic             evt_q_o
);
   localparam int HALF = CNT_W / 2;

   if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_width
      $error("bct_count_core: CNT_W must be even and at least 4");
   end

   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             out_q, out_n;
   logic             run_q, run_n;
   logic             sb_q, sb_n;
   logic             evt, evt_q;
   logic             init_lvl;
   logic [HALF-1:0]  lo_q, hi_q;
   tmr_mode_e        mode;

   assign init_lvl = start_level(out_init_i);
   assign lo_q     = cnt_q[HALF-1:0];
   assign hi_q     = cnt_q[CNT_W-1:HALF];
   assign mode     = tmr_mode_e'(mode_i);

   always_comb begin
      cnt_n = cnt_q;
      out_n = out_q;
      run_n = run_q;
      sb_n  = sb_q;
      evt   = 1'b0;
      if (!arm_i) begin
         cnt_n = cnt_q;
      end else if (start_i) begin
         cnt_n = cmp_i;
         out_n = init_lvl;
         run_n = 1'b1;
         sb_n  = start_bit_i;
      end else if (run_q && rst_cond_i) begin
         cnt_n = cmp_i;
         if (out_init_i[1]) out_n = init_lvl;
      end else if (run_q && sb_q && sclk_rise_i) begin
         cnt_n = cmp_i;
         sb_n  = 1'b0;
      end else if (run_q && tick_i) begin
         unique case (mode)
            MODE_CASCADE: begin
               if (lo_q == '0) begin
                  if (hi_q == '0) begin
                     evt = 1'b1;
                  end else begin
                     cnt_n[HALF-1:0]     = cmp_i[HALF-1:0];
                     cnt_n[CNT_W-1:HALF] = hi_q - HALF'(1);
                     out_n               = ~out_q;
                  end
               end else begin
                  cnt_n[HALF-1:0] = lo_q - HALF'(1);
               end
            end
            MODE_PWM: begin
               if (out_q) begin
                  if (lo_q == '0) out_n = 1'b0;
                  else            cnt_n[HALF-1:0] = lo_q - HALF'(1);
               end else begin
                  if (hi_q == '0) begin
                     if (lo_q == '0) evt = 1'b1;
                     else            out_n = 1'b1;
                  end else begin
                     cnt_n[CNT_W-1:HALF] = hi_q - HALF'(1);
                  end
               end
            end
            default: begin
               if (cnt_q == '0) evt = 1'b1;
               else             cnt_n = cnt_q - CNT_W'(1);
            end
         endcase
         if (evt) begin
            cnt_n = cmp_i;
            out_n = ~out_q;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         out_q <= 1'b0;
         run_q <= 1'b0;
         sb_q  <= 1'b0;
         evt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         out_q <= out_n;
         run_q <= run_n;
         sb_q  <= sb_n;
         evt_q <= evt;
      end
   end

   assign out_o   = out_q;
   assign run_o   = run_q;
   assign evt_o   = evt;
   assign evt_q_o = evt_q;

   // R2
   start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && start_i) |=> (cnt_q == $past(cmp_i)));

   // R12
   hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !arm_i |=> (cnt_q == $past(cnt_q)));

   // R10
   evt_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt |=> (out_q != $past(out_q)));
endmodule

// File: rtl/bct_flag.sv
module bct_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R11
   clear_wins_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !flag_q);

   // R10
   set_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_q);
endmodule

// File: rtl/bitclk_timer.sv
module bitclk_timer
   import bct_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,
   input  logic             start_i,
   input  logic             rst_cond_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       dec_sel_i,
   input  logic [1:0]       out_init_i,
   input  logic             start_bit_i,
   input  logic             pin_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             flag_clr_i,
   output logic             tmr_out_o,
   output logic             shift_clk_o,
   output logic             flag_o,
   output logic             tx_load_o,
   output logic             rx_store_o
);
   logic pin_lvl, pin_edge;
   logic tick, sclk_raw, sclk_q, sclk_rise, live;
   logic out_q, run_q, evt, evt_q;

   bct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i),
      .level_o (pin_lvl),
      .edge_o  (pin_edge)
   );

   assign tick      = (dec_sel_i == 2'b00) ? 1'b1 : pin_edge;
   assign live      = run_q & arm_i;
   assign sclk_raw  = dec_sel_i[1] ? (pin_lvl ^ dec_sel_i[0]) : out_q;
   assign sclk_rise = shift_clk_o & ~sclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sclk_q <= 1'b0;
      else         sclk_q <= shift_clk_o;
   end

   bct_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .arm_i       (arm_i),
      .start_i     (start_i),
      .rst_cond_i  (rst_cond_i),
      .tick_i      (tick),
      .sclk_rise_i (sclk_rise),
      .start_bit_i (start_bit_i),
      .mode_i      (mode_i),
      .out_init_i  (out_init_i),
      .cmp_i       (cmp_i),
      .out_o       (out_q),
      .run_o       (run_q),
      .evt_o       (evt),
      .evt_q_o     (evt_q)
   );

   bct_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt),
      .clr_i  (flag_clr_i),
      .flag_o (flag_o)
   );

   assign shift_clk_o = live & sclk_raw;
   assign tmr_out_o   = live ? out_q : start_level(out_init_i);
   assign tx_load_o   = evt_q;
   assign rx_store_o  = evt_q;

   // R10
   strobe_with_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> tx_load_o);
endmodule

// File: tb/bitclk_timer_bench.sv
module bitclk_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b1, start = 1'b0, rcond = 1'b0, sbit = 1'b0, pin = 1'b0, fclr = 1'b0;
   logic [1:0]  mode = 2'b10, dsel = 2'b00, oinit = 2'b00;
   logic [15:0] cmp = 16'd0;
   logic        tout, sclk, flag, txl, rxs;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   bitclk_timer u_bitclk_timer (
      .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .start_i(start), .rst_cond_i(rcond),
      .mode_i(mode), .dec_sel_i(dsel), .out_init_i(oinit), .start_bit_i(sbit),
      .pin_i(pin), .cmp_i(cmp), .flag_clr_i(fclr), .tmr_out_o(tout),
      .shift_clk_o(sclk), .flag_o(flag), .tx_load_o(txl), .rx_store_o(rxs)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic go(input logic [1:0] m, input logic [1:0] d, input logic [1:0] oi,
                     input logic sb, input logic [15:0] c);
      @(negedge clk);
      mode = m; dsel = d; oinit = oi; sbit = sb; cmp = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); fclr = 1'b1;
      @(negedge clk); fclr = 1'b0;
   endtask

   task automatic pin_step();
      @(negedge clk); pin = ~pin;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(tout == 1'b1 && sclk == 1'b0, "R1 out/shift", {tout, sclk}, 2);
      chk(flag == 1'b0 && txl == 1'b0 && rxs == 1'b0, "R1 flag/strobes", {flag, txl, rxs}, 0);
   endtask

   task automatic t_wide();
      int first = 0;
      go(2'b10, 2'b00, 2'b00, 1'b0, 16'd5);
      chk(tout == 1'b1, "R2 start level high", tout, 1);
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (txl && first == 0) first = k;
      end
      chk(first == 6, "R9 compare step", first, 6);
      chk(tout == 1'b0 && flag == 1'b1 && rxs == 1'b1, "R10 compare effects", {tout, flag, rxs}, 3);
      @(negedge clk);
      chk(txl == 1'b0, "R10 strobe one cycle", txl, 0);
      go(2'b10, 2'b00, 2'b01, 1'b0, 16'd5);
      chk(tout == 1'b0, "R2 start level low", tout, 0);
   endtask

   task automatic t_cascade();
      int tog = 0, ld = 0;
      logic prev;
      go(2'b00, 2'b00, 2'b00, 1'b0, {8'd2, 8'd3});
      prev = tout;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (tout != prev && tog == 0) tog = k;
         if (txl && ld == 0) ld = k;
         prev = tout;
      end
      chk(tog == 4, "R7 first toggle", tog, 4);
      chk(ld == 12, "R7 compare step", ld, 12);
   endtask

   task automatic t_pwm();
      int fall = 0, rise = 0, ld = 0;
      logic prev;
      go(2'b01, 2'b00, 2'b00, 1'b0, {8'd1, 8'd2});
      prev = tout;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (prev && !tout && fall == 0) fall = k;
         if (!prev && tout && rise == 0) rise = k;
         if (txl && ld == 0) ld = k;
         prev = tout;
      end
      chk(fall == 3, "R8 high phase", fall, 3);
      chk(rise == 5 && ld == 5, "R8 low phase end", rise * 10 + ld, 55);
   endtask

   task automatic t_rcond(input logic [1:0] oi, input logic exp_out);
      int ld = 0;
      go(2'b10, 2'b00, oi, 1'b0, 16'd2);
      repeat (3) @(negedge clk);
      rcond = 1'b1;
      @(negedge clk);
      rcond = 1'b0;
      chk(tout == exp_out, "R5 output after restart", tout, exp_out);
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if (txl && ld == 0) ld = k;
      end
      chk(ld == 3, "R5 reload timing", ld, 3);
   endtask

   task automatic t_disarm();
      int ld = 0;
      go(2'b10, 2'b00, 2'b00, 1'b0, 16'd2);
      repeat (4) @(negedge clk);
      arm = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk(tout == 1'b1 && sclk == 1'b0 && txl == 1'b0, "R12 disarmed outputs", {tout, sclk, txl}, 4);
      end
      arm = 1'b1;
      for (int k = 1; k <= 2; k++) begin
         @(negedge clk);
         if (txl && ld == 0) ld = k;
      end
      chk(ld == 2, "R12 resume from held count", ld, 2);
   endtask

   task automatic t_pin();
      go(2'b10, 2'b01, 2'b00, 1'b0, 16'd3);
      clear_flag();
      repeat (3) pin_step();
      chk(flag == 1'b0, "R4 three edges no compare", flag, 0);
      chk(sclk == tout, "R3 shift equals output", sclk, tout);
      pin_step();
      chk(flag == 1'b1, "R4 fourth edge compare", flag, 1);
   endtask

   task automatic t_sclk_src();
      dsel = 2'b10;
      pin_step();
      chk(sclk == pin, "R3 shift equals pin", sclk, pin);
      dsel = 2'b11;
      @(negedge clk);
      chk(sclk == ~pin, "R3 shift inverted pin", sclk, ~pin);
      if (pin) pin_step();
   endtask

   task automatic t_startbit();
      go(2'b10, 2'b10, 2'b00, 1'b1, 16'd3);
      clear_flag();
      repeat (4) pin_step();
      chk(flag == 1'b0, "R6 no compare after four edges", flag, 0);
      pin_step();
      chk(flag == 1'b1, "R6 compare on fifth edge", flag, 1);
      pin_step();
   endtask

   task automatic t_flag();
      go(2'b10, 2'b00, 2'b00, 1'b0, 16'd3);
      fclr = 1'b1;
      @(negedge clk);
      chk(flag == 1'b0, "R11 clear", flag, 0);
      repeat (3) @(negedge clk);
      chk(flag == 1'b1, "R11 set beats clear", flag, 1);
      @(negedge clk);
      chk(flag == 1'b0, "R11 clear later", flag, 0);
      fclr = 1'b0;
      @(negedge clk);
      chk(flag == 1'b0, "R11 stays clear", flag, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide();
      t_cascade();
      t_pwm();
      t_rcond(2'b10, 1'b1);
      t_rcond(2'b00, 1'b0);
      t_disarm();
      t_pin();
      t_sclk_src();
      t_startbit();
      t_flag();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule